// File: doc/BRIEF.md
# Half-Duplex Transmit Outcome Tracker

This block follows a single Ethernet frame from the moment the host arms a transmission until the frame either leaves the wire or is given up. While a frame is active it receives one-cycle event pulses from the transmit engine: a defer, a collision together with the byte offset reached in the frame, a data underrun, and a success pulse at the end of a clean attempt. For each collision it decides whether the engine must try again or whether the frame is abandoned. Three collision limits apply: a 16-collision ceiling, an immediate give-up when retries are disabled, and a 64-byte late-collision window.

When the frame finishes, the block captures a 32-bit outcome word and raises a done flag. Both stay unchanged until the host arms the next frame. The mode bits (half duplex, retries disabled, give up on late collision) are sampled when the frame is armed. In full-duplex mode, collision pulses are ignored and every collision-related field reads as zero. If a frame is given up, the host must send it again.

Top module: `hdt_status_collector`

## Requirements
- R1: An arm pulse (`start_i`) clears the outcome word to zero and drops `done_o` on the next cycle. Event pulses that arrive while no frame is active leave `done_o`, `retry_o` and the outcome word unchanged.
- R2: Outcome word layout: bit 31 = resend-needed, bits 13:10 = collision count, bit 9 = late-collision-then-retried, bit 8 = deferred, bit 7 = underrun, bit 6 = too-many-collisions, bit 5 = late-collision give-up, bit 0 = frame-given-up. Bits 30:14 and 4:1 always read zero.
- R3: A success pulse ends the frame with bits 31, 7, 6, 5 and 0 clear. The collision count equals the number of collisions taken, saturating at 15.
- R4: In half duplex, a collision at an offset below 64, below the limit and with retries enabled, produces a one-cycle `retry_o` pulse on the cycle after the collision.
- R5: The 16th collision of a frame gives the frame up. It sets bits 6, 0 and 31 and produces no retry pulse.
- R6: With retries disabled, the first collision gives the frame up and sets bits 6, 0 and 31.
- R7: A collision at offset 64 or above with late give-up enabled ends the frame with bits 5, 0 and 31 set. This rule takes precedence over the retries-disabled rule.
- R8: A collision at offset 64 or above with late give-up disabled is handled as an ordinary retry that counts toward the limit, and it sets bit 9 in the final word.
- R9: An underrun gives the frame up in either duplex mode and sets bits 7, 0 and 31.
- R10: A defer pulse during a half-duplex frame sets bit 8.
- R11: In full duplex, collisions produce no retry and are not counted, and bits 13:8, 6 and 5 read zero.
- R12: After a frame ends, `done_o` stays high and the outcome word stays stable until the next arm pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm pulse for a new frame |
| defer_i | input | 1 | Defer event pulse |
| coll_i | input | 1 | Collision event pulse |
| coll_ofs_i | input | OFS_W | Byte offset into the frame at the collision |
| underrun_i | input | 1 | Data underrun event pulse |
| attempt_ok_i | input | 1 | Attempt finished cleanly |
| half_duplex_i | input | 1 | Half-duplex mode, sampled at arm |
| no_retry_i | input | 1 | Retries disabled, sampled at arm |
| late_abort_i | input | 1 | Give up on late collision, sampled at arm |
| retry_o | output | 1 | Request another attempt |
| done_o | output | 1 | Frame finished, word valid |
| status_o | output | 32 | Latched outcome word |

## Verification
A wrong collision counter shows up in two ways: a retry pulse may be missing, or an extra one may appear, on the cycle right after the 16th collision. A wrong count also shows in bits 13:10 as soon as `done_o` rises. A wrongly stored flag (defer or late-then-retried) stays hidden until the frame ends, and then appears in the word on the same cycle as `done_o`. A phase register stuck in the wrong state shows at once: `done_o` fails to drop one cycle after arming, or events after completion change the held word. The sweep runs every count from 0 to 16 against every mode combination, so that each of these faults is observed within one frame.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
   localparam int STAT_W = 32;
   localparam int PR_BIT = 31;
   localparam int CC_LSB = 10;
   localparam int CC_W   = 4;
   localparam int LO_BIT = 9;
   localparam int DF_BIT = 8;
   localparam int UR_BIT = 7;
   localparam int EC_BIT = 6;
   localparam int LC_BIT = 5;
   localparam int FA_BIT = 0;

   typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_t;
   typedef enum logic [1:0] {VERD_NONE, VERD_RETRY, VERD_GIVEUP_EC, VERD_GIVEUP_LC} verdict_t;

   typedef struct packed {
      logic            lo;
      logic            df;
      logic            ur;
      logic            ec;
      logic            lc;
      logic [CC_W-1:0] cc;
   } outcome_t;
endpackage

// File: rtl/hdt_coll_judge.sv
module hdt_coll_judge
   import hdt_pkg::*;
#(
   parameter int OFS_W      = 11,
   parameter int LATE_WIN   = 64,
   parameter int COLL_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             hit_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             no_retry_i,
   input  logic             late_abort_i,
   output verdict_t         verdict_o,
   output logic             late_o,
   output logic [CC_W-1:0]  cc_o
);
   localparam int CNT_W  = $clog2(COLL_LIMIT + 1);
   localparam int CC_MAX = (1 << CC_W) - 1;

   logic [CNT_W-1:0] cnt_q, cnt_next, cnt_use;
   logic             at_limit;

   assign cnt_next = cnt_q + CNT_W'(1);
   assign at_limit = (cnt_next == CNT_W'(COLL_LIMIT));
   assign late_o   = (ofs_i >= OFS_W'(LATE_WIN));
   assign cnt_use  = hit_i ? cnt_next : cnt_q;

   always_comb begin
      if (!hit_i)                     verdict_o = VERD_NONE;
      else if (late_o && late_abort_i) verdict_o = VERD_GIVEUP_LC;
      else if (no_retry_i)            verdict_o = VERD_GIVEUP_EC;
      else if (at_limit)              verdict_o = VERD_GIVEUP_EC;
      else                            verdict_o = VERD_RETRY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) cnt_q <= '0;
      else if (hit_i)        cnt_q <= cnt_next;
   end

   generate
      if (CNT_W > CC_W) begin : g_sat
         assign cc_o = (cnt_use > CNT_W'(CC_MAX)) ? CC_W'(CC_MAX) : cnt_use[CC_W-1:0];
      end else begin : g_ext
         assign cc_o = CC_W'(cnt_use);
      end
   endgenerate
endmodule

// File: rtl/hdt_status_pack.sv
module hdt_status_pack
   import hdt_pkg::*;
(
   input  outcome_t            oc_i,
   input  logic                gave_up_i,
   input  logic                half_duplex_i,
   output logic [STAT_W-1:0]   word_o
);
   always_comb begin
      word_o                     = '0;
      word_o[PR_BIT]             = gave_up_i;
      word_o[FA_BIT]             = gave_up_i;
      word_o[UR_BIT]             = oc_i.ur;
      if (half_duplex_i) begin
         word_o[CC_LSB +: CC_W]  = oc_i.cc;
         word_o[LO_BIT]          = oc_i.lo;
         word_o[DF_BIT]          = oc_i.df;
         word_o[EC_BIT]          = oc_i.ec;
         word_o[LC_BIT]          = oc_i.lc;
      end
   end
endmodule

// File: rtl/hdt_status_collector.sv
module hdt_status_collector
   import hdt_pkg::*;
#(
   parameter int OFS_W      = 11,
   parameter int LATE_WIN   = 64,
   parameter int COLL_LIMIT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               defer_i,
   input  logic               coll_i,
   input  logic [OFS_W-1:0]   coll_ofs_i,
   input  logic               underrun_i,
   input  logic               attempt_ok_i,
   input  logic               half_duplex_i,
   input  logic               no_retry_i,
   input  logic               late_abort_i,
   output logic               retry_o,
   output logic               done_o,
   output logic [31:0]        status_o
);
   initial begin
      assert (COLL_LIMIT >= 1) else $error("COLL_LIMIT must be at least 1");
      assert (LATE_WIN < (1 << OFS_W)) else $error("LATE_WIN must fit in OFS_W bits");
   end

   phase_t            phase_q;
   logic              hd_q, nr_q, la_q, df_q, lo_q, retry_q;
   logic [STAT_W-1:0] status_q, word;
   logic              run, hit, ur_ev, ok_ev, gave_up, fin, late;
   logic [CC_W-1:0]   cc_now;
   verdict_t          verdict;
   outcome_t          oc;

   assign run   = (phase_q == PH_RUN);
   assign ur_ev = run && underrun_i;
   assign hit   = run && hd_q && coll_i && !underrun_i;
   assign ok_ev = run && attempt_ok_i && !underrun_i && !(coll_i && hd_q);

   hdt_coll_judge #(
      .OFS_W(OFS_W), .LATE_WIN(LATE_WIN), .COLL_LIMIT(COLL_LIMIT)
   ) i_judge (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .hit_i(hit),
      .ofs_i(coll_ofs_i), .no_retry_i(nr_q), .late_abort_i(la_q),
      .verdict_o(verdict), .late_o(late), .cc_o(cc_now)
   );

   always_comb begin
      oc.lo = lo_q;
      oc.df = df_q || (run && defer_i);
      oc.ur = ur_ev;
      oc.ec = (verdict == VERD_GIVEUP_EC);
      oc.lc = (verdict == VERD_GIVEUP_LC);
      oc.cc = cc_now;
   end

   assign gave_up = oc.ur || oc.ec || oc.lc;
   assign fin     = gave_up || ok_ev;

   hdt_status_pack i_pack (
      .oc_i(oc), .gave_up_i(gave_up), .half_duplex_i(hd_q), .word_o(word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         status_q <= '0;
         {hd_q, nr_q, la_q, df_q, lo_q, retry_q} <= '0;
      end else if (start_i) begin
         phase_q  <= PH_RUN;
         status_q <= '0;
         hd_q     <= half_duplex_i;
         nr_q     <= no_retry_i;
         la_q     <= late_abort_i;
         {df_q, lo_q, retry_q} <= '0;
      end else begin
         retry_q <= (verdict == VERD_RETRY);
         if (run && defer_i) df_q <= 1'b1;
         if (verdict == VERD_RETRY && late) lo_q <= 1'b1;
         if (fin) begin
            status_q <= word;
            phase_q  <= PH_DONE;
         end
      end
   end

   assign retry_o  = retry_q;
   assign done_o   = (phase_q == PH_DONE);
   assign status_o = status_q;
endmodule

module hdt_status_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        coll_i,
   input logic        half_duplex_i,
   input logic        no_retry_i,
   input logic        retry_o,
   input logic        done_o,
   input logic [31:0] status_o
);
   // R1
   arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && status_o == 32'h0));
   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[30:14] == '0 && status_o[4:1] == '0));
   // R12
   held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(status_o)));
   // R4
   retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |-> $past(coll_i));
   // R6
   no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_retry_i |-> !retry_o);
   // R11
   full_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_o) && !half_duplex_i) |-> (status_o[13:8] == '0 && status_o[6:5] == '0));
   // R9
   underrun_giveup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] |-> (status_o[0] && status_o[31]));
   // R5
   ec_giveup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6] |-> (status_o[0] && status_o[31] && !retry_o));
   // R3
   clean_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_o) && !status_o[0]) |-> (status_o[7:5] == '0 && !status_o[31]));
endmodule

bind hdt_status_collector hdt_status_checker i_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .coll_i(coll_i),
   .half_duplex_i(half_duplex_i), .no_retry_i(no_retry_i),
   .retry_o(retry_o), .done_o(done_o), .status_o(status_o)
);

// File: tb/test_hdt_status_collector.sv
module test_hdt_status_collector;
   localparam int OFS_W = 11;
   localparam int WIN   = 64;
   localparam int LIM   = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, defer_i = 0, coll_i = 0, underrun_i = 0, attempt_ok_i = 0;
   logic half_duplex_i = 0, no_retry_i = 0, late_abort_i = 0;
   logic [OFS_W-1:0] coll_ofs_i = '0;
   logic retry_o, done_o;
   logic [31:0] status_o;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   hdt_status_collector #(.OFS_W(OFS_W), .LATE_WIN(WIN), .COLL_LIMIT(LIM)) i_hdt_status_collector (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .defer_i(defer_i), .coll_i(coll_i),
      .coll_ofs_i(coll_ofs_i), .underrun_i(underrun_i), .attempt_ok_i(attempt_ok_i),
      .half_duplex_i(half_duplex_i), .no_retry_i(no_retry_i), .late_abort_i(late_abort_i),
      .retry_o(retry_o), .done_o(done_o), .status_o(status_o)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input int which, input int ofs);
      @(negedge clk);
      coll_ofs_i = OFS_W'(ofs);
      case (which)
         0: start_i = 1;
         1: defer_i = 1;
         2: coll_i = 1;
         3: underrun_i = 1;
         default: attempt_ok_i = 1;
      endcase
      @(negedge clk);
      {start_i, defer_i, coll_i, underrun_i, attempt_ok_i} = '0;
   endtask

   task automatic run_frame(input bit hd, input bit nr, input bit la, input int n,
                            input bit late_last, input bit dfr, input bit end_ur);
      bit gone, lo, ec, lc, ur;
      int cnt;
      logic [31:0] exp;
      gone = 0; lo = 0; ec = 0; lc = 0; ur = 0; cnt = 0;
      @(negedge clk);
      half_duplex_i = hd; no_retry_i = nr; late_abort_i = la;
      pulse(0, 0);
      chk({31'd0, done_o}, 32'd0, "R1 done after arm");
      chk(status_o, 32'd0, "R1 word after arm");
      if (dfr) pulse(1, 0);
      for (int k = 1; k <= n; k++) begin
         bit lt, rexp;
         lt = late_last && (k == n);
         rexp = 0;
         pulse(2, lt ? WIN : WIN - 1);
         if (hd && !gone) begin
            cnt++;
            if (lt && la)        begin lc = 1; gone = 1; end
            else if (nr)         begin ec = 1; gone = 1; end
            else if (cnt == LIM) begin ec = 1; gone = 1; end
            else begin rexp = 1; if (lt) lo = 1; end
         end
         chk({31'd0, retry_o}, {31'd0, rexp},
             hd ? (lt ? (la ? "R7 late giveup" : "R8 late retry") :
                   (nr ? "R6 no retry" : (cnt >= LIM ? "R5 limit" : "R4 retry")))
                : "R11 full duplex collision");
      end
      if (!gone) begin
         if (end_ur) begin ur = 1; gone = 1; pulse(3, 0); end
         else pulse(4, 0);
      end
      exp = '0;
      exp[31] = gone; exp[0] = gone; exp[7] = ur;
      if (hd) begin
         exp[13:10] = 4'((cnt > 15) ? 15 : cnt);
         exp[9] = lo; exp[8] = dfr; exp[6] = ec; exp[5] = lc;
      end
      chk({31'd0, done_o}, 32'd1, "R12 done raised");
      chk(status_o, exp, ur ? "R9 underrun word" : (!gone ? (dfr ? "R10 defer word" : "R3 success word") : "R2 giveup word"));
      pulse(2, WIN); pulse(3, 0); pulse(4, 0); pulse(1, 0);
      chk({31'd0, retry_o}, 32'd0, "R1 no retry when idle");
      chk(status_o, exp, "R12 word held");
      chk({31'd0, done_o}, 32'd1, "R12 done held");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk({30'd0, retry_o, done_o}, 32'd0, "R1 reset outputs");
      chk(status_o, 32'd0, "R1 reset word");
      pulse(2, 10); pulse(3, 0);
      chk({30'd0, retry_o, done_o}, 32'd0, "R1 events before arm ignored");
      chk(status_o, 32'd0, "R1 word before arm");
      for (int hd = 0; hd < 2; hd++)
         for (int nr = 0; nr < 2; nr++)
            for (int la = 0; la < 2; la++)
               for (int n = 0; n <= LIM; n++)
                  for (int ll = 0; ll < 2; ll++)
                     for (int dv = 0; dv < 2; dv++)
                        for (int eu = 0; eu < 2; eu++)
                           if (!(ll == 1 && n == 0))
                              run_frame(hd[0], nr[0], la[0], n, ll[0], dv[0], eu[0]);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule